// File: doc/BRIEF.md
# Locked-instruction legality gate

This block sits in the decode stage. It looks at each decoded instruction that carries a bus-lock prefix. It decides whether that instruction is one of the few read-modify-write forms that may run as an indivisible memory operation. Only a small, fixed set of memory-destination forms qualifies. These are the bit-operation family, the exchange between a register and memory, the two-operand arithmetic and logic group with a register or immediate source, and the one-operand group acting on memory. Any other form that carries the prefix is refused. A repeated string form that carries the prefix is also refused. When the block refuses a form, it raises an invalid-opcode fault with vector 6.

An upstream decoder supplies a strobe and a handful of flags that classify the instruction. The block registers its result. In the cycle after the strobe it produces either a one-cycle fault pulse with the vector number, or a lock request that stays high until the pipeline reports that the instruction has completed. The decision has no privilege or operating-mode input, so it is made the same way at every privilege level and in every mode.

Top module: `lock_gate_check`

## Requirements
- R1: While reset is applied, and after it is released, the fault output and the lock request are low and the vector output is 0.
- R2: A decode without the lock prefix never raises a fault. It never sets the lock request, and it leaves a lock request that is already held unchanged.
- R3: Class code 1 (bit-operation family) and class code 3 (two-operand arithmetic and logic) are lockable only when the destination is memory and the source flag shows a register or immediate.
- R4: Class code 2 (exchange) is lockable only when exactly one operand is memory. That is the case when destination-is-memory equals source-is-register-or-immediate, which covers both operand orders.
- R5: Class code 4 (one-operand group) is lockable whenever the destination is memory, whatever the source flag shows.
- R6: A locked form whose memory operand is only the source is refused. Class code 0, and the unused codes 5 to 7, are refused under every combination of flags.
- R7: When the lock prefix and the repeat prefix are present together, the instruction is refused whatever its class and operand flags.
- R8: A refused decode raises a fault output that is high for exactly the one cycle after the strobe. The vector output reads 6 during that cycle and 0 in all other cycles.
- R9: A lockable decode sets the lock request in the cycle after the strobe. The request then holds until the cycle after the completion input is sampled high.
- R10: The fault and the lock request are never high in the same cycle. A refused decode also drops a lock request that is already held.
- R11: When a lockable decode and the completion input arrive in the same cycle, the lock request stays high, because the new grant takes priority.
- R12: In a cycle without the strobe or the completion input, no fault is raised and the lock request keeps its value, whatever the classification inputs show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_valid | input | 1 | Strobe: a decoded instruction is presented this cycle |
| dec_lock | input | 1 | Lock prefix present |
| dec_rep | input | 1 | Repeat prefix present |
| dec_class | input | 3 | Class code: 0 other, 1 bit-operation, 2 exchange, 3 two-operand ALU, 4 one-operand ALU, 5-7 other |
| dec_dst_mem | input | 1 | Destination operand is memory |
| dec_src_ri | input | 1 | Source operand is a register or an immediate (0: memory) |
| insn_done | input | 1 | The instruction holding the lock has completed |
| flt_pulse | output | 1 | One-cycle invalid-opcode fault |
| flt_vector | output | 8 | Fault vector number: 6 while the fault is high, 0 otherwise |
| bus_lock_req | output | 1 | Lock request held for the whole of a lockable instruction |

## Verification
Three events can land in the same cycle: a new grant, the completion of the instruction that holds the lock, and a refusal. The bench presents a lockable decode while the lock is held and raises the completion input in that same cycle, then expects the request to stay high in the following cycle. It also presents a refused decode while a lock is held, and expects the fault without the request in the following cycle. Every combination of the prefix, repeat, class and operand flags is swept from a clear state. The expected grant or refusal is computed in the bench from the class rules.

// File: rtl/lock_chk_pkg.sv
package lock_chk_pkg;

  typedef enum logic [2:0] {
    CLS_OTHER = 3'd0,
    CLS_BITOP = 3'd1,
    CLS_XCHG  = 3'd2,
    CLS_ALU2  = 3'd3,
    CLS_ALU1  = 3'd4
  } insn_cls_e;

  typedef struct packed {
    logic legal;
    logic refuse;
  } lock_verdict_t;

endpackage

// File: rtl/lock_form_decode.sv
module lock_form_decode
  import lock_chk_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input  logic             lock_i,
  input  logic             rep_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             dst_mem_i,
  input  logic             src_ri_i,
  output lock_verdict_t    verdict_o
);

  logic form_ok;

  // Whitelist of read-modify-write memory-destination forms.
  always_comb begin
    form_ok = 1'b0;
    case (cls_i)
      CLS_BITOP: form_ok = dst_mem_i & src_ri_i;
      CLS_ALU2:  form_ok = dst_mem_i & src_ri_i;
      CLS_XCHG:  form_ok = (dst_mem_i == src_ri_i);
      CLS_ALU1:  form_ok = dst_mem_i;
      default:   form_ok = 1'b0;
    endcase
  end

  always_comb begin
    verdict_o.legal  = lock_i & ~rep_i & form_ok;
    verdict_o.refuse = lock_i & ~(~rep_i & form_ok);
  end

endmodule

// File: rtl/lock_fault_gen.sv
module lock_fault_gen #(
  parameter int VEC_W  = 8,
  parameter int UD_VEC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid_i,
  input  logic             refuse_i,
  output logic             flt_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam logic [VEC_W-1:0] VEC_UD   = VEC_W'(UD_VEC);
  localparam logic [VEC_W-1:0] VEC_NONE = '0;

  logic             flt_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    flt_d = dec_valid_i & refuse_i;
    vec_d = flt_d ? VEC_UD : VEC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_o <= 1'b0;
      vec_o <= VEC_NONE;
    end else begin
      flt_o <= flt_d;
      vec_o <= vec_d;
    end
  end

endmodule

// File: rtl/lock_hold_ctl.sv
module lock_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_valid_i,
  input  logic legal_i,
  input  logic refuse_i,
  input  logic done_i,
  output logic req_o
);

  logic req_en;
  logic req_d;

  // Priority: refusal clears, grant sets, completion clears.
  always_comb begin
    req_en = (dec_valid_i & (legal_i | refuse_i)) | done_i;
    if (dec_valid_i & refuse_i)     req_d = 1'b0;
    else if (dec_valid_i & legal_i) req_d = 1'b1;
    else                            req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_o <= 1'b0;
    else if (req_en) req_o <= req_d;
  end

endmodule

// File: rtl/lock_gate_check.sv
module lock_gate_check
  import lock_chk_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int UD_VEC      = 6,
  parameter int CLS_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             dec_lock,
  input  logic             dec_rep,
  input  logic [CLS_W-1:0] dec_class,
  input  logic             dec_dst_mem,
  input  logic             dec_src_ri,
  input  logic             insn_done,
  output logic             flt_pulse,
  output logic [VEC_W-1:0] flt_vector,
  output logic             bus_lock_req
);

  logic          rst_q_n;
  lock_verdict_t verdict;

  // Reset asserts asynchronously and is released through a synchronizer.
  generate
    if (SYNC_STAGES > 1) begin : g_rsync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_q_n = sync_q[SYNC_STAGES-1];
    end else begin : g_rdirect
      assign rst_q_n = rst_n;
    end
  endgenerate

  lock_form_decode #(.CLS_W(CLS_W)) u_dec (
    .lock_i    (dec_lock),
    .rep_i     (dec_rep),
    .cls_i     (dec_class),
    .dst_mem_i (dec_dst_mem),
    .src_ri_i  (dec_src_ri),
    .verdict_o (verdict)
  );

  lock_fault_gen #(.VEC_W(VEC_W), .UD_VEC(UD_VEC)) u_flt (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .dec_valid_i (dec_valid),
    .refuse_i    (verdict.refuse),
    .flt_o       (flt_pulse),
    .vec_o       (flt_vector)
  );

  lock_hold_ctl u_hold (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .dec_valid_i (dec_valid),
    .legal_i     (verdict.legal),
    .refuse_i    (verdict.refuse),
    .done_i      (insn_done),
    .req_o       (bus_lock_req)
  );

endmodule

// File: rtl/lock_gate_check_sva.sv
module lock_gate_check_sva #(
  parameter int VEC_W  = 8,
  parameter int UD_VEC = 6
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             dec_valid,
  input logic             dec_lock,
  input logic             dec_rep,
  input logic             insn_done,
  input logic             flt_pulse,
  input logic [VEC_W-1:0] flt_vector,
  input logic             bus_lock_req
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_q_n |-> (!flt_pulse && !bus_lock_req && flt_vector == '0));

  p_no_prefix_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dec_valid && !dec_lock && !insn_done) |=> (!flt_pulse && $stable(bus_lock_req)));

  p_rep_refused_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dec_valid && dec_lock && dec_rep) |=> (flt_pulse && !bus_lock_req));

  p_fault_cause_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    flt_pulse |-> $past(dec_valid && dec_lock));

  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    flt_pulse ? (flt_vector == VEC_W'(UD_VEC)) : (flt_vector == '0));

  p_grant_cause_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(bus_lock_req) |-> $past(dec_valid && dec_lock && !dec_rep));

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (insn_done && !dec_valid) |=> !bus_lock_req);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(flt_pulse && bus_lock_req));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!dec_valid && !insn_done) |=> (!flt_pulse && $stable(bus_lock_req)));

endmodule

bind lock_gate_check lock_gate_check_sva #(.VEC_W(VEC_W), .UD_VEC(UD_VEC)) u_sva (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .dec_valid    (dec_valid),
  .dec_lock     (dec_lock),
  .dec_rep      (dec_rep),
  .insn_done    (insn_done),
  .flt_pulse    (flt_pulse),
  .flt_vector   (flt_vector),
  .bus_lock_req (bus_lock_req)
);

// File: tb/sim_lock_gate_check.sv
`timescale 1ns/1ps
module sim_lock_gate_check;

  logic       clk;
  logic       rst_n;
  logic       dec_valid, dec_lock, dec_rep, dec_dst_mem, dec_src_ri, insn_done;
  logic [2:0] dec_class;
  logic       flt_pulse, bus_lock_req;
  logic [7:0] flt_vector;

  int checks;
  int failures;
  bit finished;

  lock_gate_check u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_lock(dec_lock),
    .dec_rep(dec_rep), .dec_class(dec_class), .dec_dst_mem(dec_dst_mem),
    .dec_src_ri(dec_src_ri), .insn_done(insn_done), .flt_pulse(flt_pulse),
    .flt_vector(flt_vector), .bus_lock_req(bus_lock_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input bit l, input bit r, input int c,
                       input bit d, input bit s, input bit dn);
    dec_valid = v; dec_lock = l; dec_rep = r; dec_class = 3'(c);
    dec_dst_mem = d; dec_src_ri = s; insn_done = dn;
  endtask

  // Independent model of lockability from the requirements.
  function automatic bit model_ok(bit l, bit r, int c, bit d, bit s);
    bit rmw;
    if (!l || r) return 1'b0;
    rmw = 1'b0;
    if (c == 2) rmw = (d && s) || (!d && !s);
    else if (d) rmw = (c == 4) || ((c == 1 || c == 3) && s);
    return rmw;
  endfunction

  function automatic string tag_for(bit l, bit r, int c, bit d);
    if (!l) return "R2";
    if (r) return "R7";
    if (c == 2) return "R4";
    if (c == 0 || c > 4 || !d) return "R6";
    if (c == 4) return "R5";
    return "R3";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) step();
    chk("R1 fault in reset", int'(flt_pulse), 0);
    chk("R1 lock in reset", int'(bus_lock_req), 0);
    chk("R1 vector in reset", int'(flt_vector), 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 fault after release", int'(flt_pulse), 0);
    chk("R1 lock after release", int'(bus_lock_req), 0);

    // Full sweep of prefixes, classes and operand flags from a clear state.
    for (int k = 0; k < 128; k++) begin
      bit l = k[6];
      bit r = k[5];
      int c = (k >> 2) & 7;
      bit d = k[1];
      bit s = k[0];
      bit ok = model_ok(l, r, c, d, s);
      bit bad = l && !ok;
      string t = tag_for(l, r, c, d);
      drive(1, l, r, c, d, s, 0);
      step();
      chk({t, " fault"}, int'(flt_pulse), int'(bad));
      chk({t, " lock"}, int'(bus_lock_req), int'(ok));
      chk("R8 vector", int'(flt_vector), bad ? 6 : 0);
      chk("R10 exclusive", int'(flt_pulse && bus_lock_req), 0);
      drive(0, l, r, c, d, s, 0);
      step();
      chk("R8 single pulse", int'(flt_pulse), 0);
      chk("R12 hold", int'(bus_lock_req), int'(ok));
      drive(0, 0, 0, 0, 0, 0, 1);
      step();
      chk("R9 done clears", int'(bus_lock_req), 0);
      drive(0, 0, 0, 0, 0, 0, 0);
    end

    // Grant and completion together: grant wins.
    drive(1, 1, 0, 3, 1, 1, 0); step();
    chk("R9 grant", int'(bus_lock_req), 1);
    drive(1, 1, 0, 4, 1, 0, 1); step();
    chk("R11 grant beats done", int'(bus_lock_req), 1);
    chk("R11 no fault", int'(flt_pulse), 0);

    // Unlocked decode while held leaves the lock.
    drive(1, 0, 0, 0, 0, 0, 0); step();
    chk("R2 held lock kept", int'(bus_lock_req), 1);
    chk("R2 no fault", int'(flt_pulse), 0);

    // Idle with illegal-looking inputs but no strobe.
    drive(0, 1, 1, 0, 0, 0, 0); step();
    chk("R12 no strobe no fault", int'(flt_pulse), 0);
    chk("R12 lock kept", int'(bus_lock_req), 1);

    // Refusal while held drops the lock.
    drive(1, 1, 0, 3, 0, 0, 0); step();
    chk("R10 fault while held", int'(flt_pulse), 1);
    chk("R10 lock dropped", int'(bus_lock_req), 0);
    chk("R8 vector 6", int'(flt_vector), 6);

    // Back-to-back refusals give a fault each cycle; then quiet.
    drive(1, 1, 1, 1, 1, 1, 0); step();
    chk("R7 rep refused", int'(flt_pulse), 1);
    drive(0, 0, 0, 0, 0, 0, 0); step();
    chk("R8 pulse ends", int'(flt_pulse), 0);
    chk("R8 vector cleared", int'(flt_vector), 0);

    // Reset while held clears everything.
    drive(1, 1, 0, 2, 0, 0, 0); step();
    chk("R4 reg-from-mem exchange", int'(bus_lock_req), 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0; step();
    chk("R1 reset drops lock", int'(bus_lock_req), 0);
    rst_n = 1'b1; repeat (3) step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule